// File: doc/BRIEF.md
# Control Register Write Handler

This block owns the two mode-control registers of a processor core: the primary mode register (index 0) and the extension-enable register (index 4). A single-cycle strobe with a register index and a 32-bit word writes one of them. Alongside the stored values the block keeps a small vector of hidden mode flags in step, decides when the core enters or leaves long mode, and raises one-cycle requests to flush address translations and to truncate the instruction pointer.

The long-mode enable and current long-mode-active bits come from the extended-feature register, which lives outside. The block returns the updated long-mode-active bit for that register to store. A SIMD-present input gates one extension bit, and a code-segment long attribute input feeds the 64-bit-code hidden flag. Writes are plain strobes with no back-pressure: every strobe is taken on the next rising edge, and back-to-back strobes are legal.

Top module: `crw_top`

## Requirements
- R1: While reset is low and on release, cr0_o is 0x60000010, computed by the same update logic as a write of that value over an all-zero register. cr4_o is 0, efer_lma_o is 0, hflags_o is 0x02 and both pulses are 0.
- R2: A strobe with wr_idx 0 writes the primary register and wr_idx 4 writes the extension register. The outputs change on the rising edge after the strobe. Any other index, or a cycle with wr_en low, leaves both registers unchanged.
- R3: Bit 4 of cr0_o reads 1 after every primary write, whatever value was written.
- R4: flush_o is high for exactly the cycle after a primary write in which bit 31, bit 16 or bit 0 differs between the old and new value. No flush is raised when all three bits are unchanged.
- R5: hflags_o bit 0 copies primary bit 0. Bits 2, 3 and 4 copy primary bits 1, 2 and 3. Bit 1 is set whenever bit 0 is 0 and stays set until reset.
- R6: A primary write that takes bit 31 from 0 to 1 while efer_lme_i is 1 and cr4_o bit 5 is 1 sets efer_lma_o and hflags_o bit 5. If cr4_o bit 5 or efer_lme_i is 0, long mode is not entered.
- R7: A primary write that takes bit 31 from 1 to 0 while efer_lma_i is 1 clears efer_lma_o and hflags_o bits 5 and 6, and pulses ip_trunc_o for one cycle.
- R8: Outside those two transitions, efer_lma_o and hflags_o bit 5 follow efer_lma_i one cycle later. hflags_o bit 6 is the registered AND of the next long-mode-active value and cs_long_i.
- R9: flush_o is high for the cycle after an extension write that changes bit 4, 5 or 7. Changing only other bits raises no flush.
- R10: Extension bit 9 is stored as 0 when sse_i is 0. hflags_o bit 7 always equals stored extension bit 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 3 | Register index (0 primary, 4 extension) |
| wr_data | input | 32 | Write value |
| efer_lme_i | input | 1 | Long-mode enable from extended-feature register |
| efer_lma_i | input | 1 | Current long-mode-active bit |
| sse_i | input | 1 | SIMD extension present |
| cs_long_i | input | 1 | Code segment carries the 64-bit attribute |
| cr0_o | output | 32 | Stored primary mode register |
| cr4_o | output | 32 | Stored extension register |
| efer_lma_o | output | 1 | Updated long-mode-active bit |
| hflags_o | output | 8 | Hidden flags: 0 PE, 1 ADDSEG, 2 MP, 3 EM, 4 TS, 5 LMA, 6 CS64, 7 OSFXSR |
| flush_o | output | 1 | One-cycle translation flush request |
| ip_trunc_o | output | 1 | One-cycle instruction pointer truncate request |

## Verification
The bench builds the block with its default parameters: a 32-bit word, a 3-bit index with the primary register at 0 and the extension register at 4, and the 0x60000010 reset word. A 3-bit index leaves unused slots such as 3 that the bench can write to check that they are ignored. The stimulus table drives long mode in and out in the order that matters. Paging is first enabled without the extension enabled, so no entry happens. Paging is then cleared and set again with the extension enabled, which enters long mode, and cleared while long mode is active, which exits and truncates.

// File: rtl/crw_pkg.sv
package crw_pkg;
  localparam int CR_W = 32;

  // primary register bit positions
  localparam int P_PE = 0;
  localparam int P_MP = 1;
  localparam int P_ET = 4;
  localparam int P_WP = 16;
  localparam int P_PG = 31;

  // extension register bit positions
  localparam int X_PSE    = 4;
  localparam int X_PAE    = 5;
  localparam int X_PGE    = 7;
  localparam int X_OSFXSR = 9;

  typedef struct packed {
    logic osfxsr;
    logic cs64;
    logic lma;
    logic ts;
    logic em;
    logic mp;
    logic addseg;
    logic pe;
  } hflags_t;
endpackage

// File: rtl/crw_cr0_next.sv
module crw_cr0_next
  import crw_pkg::*;
#(
  parameter int W = CR_W
) (
  input  logic [W-1:0] old_cr,
  input  logic [W-1:0] wdata,
  input  logic         lme,
  input  logic         lma_cur,
  input  logic         pae_on,
  input  logic         addseg_old,
  output logic [W-1:0] new_cr,
  output logic         pe,
  output logic         addseg,
  output logic [2:0]   fpu,
  output logic         flush_req,
  output logic         enter_lm,
  output logic         leave_lm
);
  localparam logic [W-1:0] WATCH = (W'(1) << P_PG) | (W'(1) << P_WP) | (W'(1) << P_PE);
  localparam logic [W-1:0] ET_M  = W'(1) << P_ET;

  logic [W-1:0] diff;
  logic         pg_old;
  logic         pg_new;

  always_comb begin
    new_cr = wdata | ET_M;
    diff   = (old_cr ^ new_cr) & WATCH;
    pg_old = old_cr[P_PG];
    pg_new = new_cr[P_PG];
  end

  assign flush_req = |diff;
  assign enter_lm  = !pg_old && pg_new && lme && pae_on;
  assign leave_lm  = pg_old && !pg_new && lma_cur;
  assign pe        = new_cr[P_PE];
  assign addseg    = addseg_old | ~new_cr[P_PE];

  for (genvar i = 0; i < 3; i++) begin : g_fpu
    assign fpu[i] = new_cr[P_MP + i];
  end
endmodule

// File: rtl/crw_cr4_next.sv
module crw_cr4_next
  import crw_pkg::*;
#(
  parameter int W = CR_W,
  parameter bit GATE_FX = 1'b1
) (
  input  logic [W-1:0] old_cr,
  input  logic [W-1:0] wdata,
  input  logic         sse_on,
  output logic [W-1:0] new_cr,
  output logic         flush_req
);
  localparam logic [W-1:0] WATCH = (W'(1) << X_PGE) | (W'(1) << X_PAE) | (W'(1) << X_PSE);
  localparam logic [W-1:0] FX_M  = W'(1) << X_OSFXSR;

  if (GATE_FX) begin : g_gate
    assign new_cr = sse_on ? wdata : (wdata & ~FX_M);
  end else begin : g_pass
    logic unused_sse;
    assign unused_sse = sse_on;
    assign new_cr     = wdata;
  end

  assign flush_req = |((old_cr ^ new_cr) & WATCH);
endmodule

// File: rtl/crw_top.sv
module crw_top
  import crw_pkg::*;
#(
  parameter int          W         = CR_W,
  parameter int          IDX_W     = 3,
  parameter int          CR0_IDX   = 0,
  parameter int          CR4_IDX   = 4,
  parameter logic [31:0] RESET_CR0 = 32'h6000_0010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [W-1:0]     wr_data,
  input  logic             efer_lme_i,
  input  logic             efer_lma_i,
  input  logic             sse_i,
  input  logic             cs_long_i,
  output logic [W-1:0]     cr0_o,
  output logic [W-1:0]     cr4_o,
  output logic             efer_lma_o,
  output logic [7:0]       hflags_o,
  output logic             flush_o,
  output logic             ip_trunc_o
);
  localparam logic [IDX_W-1:0] SEL0 = IDX_W'(CR0_IDX);
  localparam logic [IDX_W-1:0] SEL4 = IDX_W'(CR4_IDX);

  logic wr0, wr4;
  assign wr0 = wr_en && (wr_idx == SEL0);
  assign wr4 = wr_en && (wr_idx == SEL4);

  logic [W-1:0] cr0_q, cr4_q;
  logic         pe_q, addseg_q, lma_q, cs64_q, flush_q, trunc_q;
  logic [2:0]   fpu_q;

  // live write path
  logic [W-1:0] n0;
  logic         n_pe, n_addseg, f0, ent, lev;
  logic [2:0]   n_fpu;
  crw_cr0_next #(.W(W)) u_cr0 (
    .old_cr(cr0_q), .wdata(wr_data), .lme(efer_lme_i), .lma_cur(efer_lma_i),
    .pae_on(cr4_q[X_PAE]), .addseg_old(addseg_q),
    .new_cr(n0), .pe(n_pe), .addseg(n_addseg), .fpu(n_fpu),
    .flush_req(f0), .enter_lm(ent), .leave_lm(lev)
  );

  // reset value through the same path, from an all-zero state
  logic [W-1:0] r0;
  logic         r_pe, r_addseg, r_f, r_ent, r_lev;
  logic [2:0]   r_fpu;
  crw_cr0_next #(.W(W)) u_cr0_rst (
    .old_cr('0), .wdata(W'(RESET_CR0)), .lme(1'b0), .lma_cur(1'b0),
    .pae_on(1'b0), .addseg_old(1'b0),
    .new_cr(r0), .pe(r_pe), .addseg(r_addseg), .fpu(r_fpu),
    .flush_req(r_f), .enter_lm(r_ent), .leave_lm(r_lev)
  );

  logic [W-1:0] n4;
  logic         f4;
  crw_cr4_next #(.W(W), .GATE_FX(1'b1)) u_cr4 (
    .old_cr(cr4_q), .wdata(wr_data), .sse_on(sse_i),
    .new_cr(n4), .flush_req(f4)
  );

  logic lma_n;
  always_comb begin
    if (wr0 && ent)      lma_n = 1'b1;
    else if (wr0 && lev) lma_n = 1'b0;
    else                 lma_n = efer_lma_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr0_q    <= r0;
      pe_q     <= r_pe;
      addseg_q <= r_addseg;
      fpu_q    <= r_fpu;
      cr4_q    <= '0;
      lma_q    <= r_ent;
      cs64_q   <= 1'b0;
      flush_q  <= r_f;
      trunc_q  <= r_lev;
    end else begin
      flush_q <= (wr0 && f0) || (wr4 && f4);
      trunc_q <= wr0 && lev;
      lma_q   <= lma_n;
      cs64_q  <= lma_n && cs_long_i;
      if (wr0) begin
        cr0_q    <= n0;
        pe_q     <= n_pe;
        addseg_q <= n_addseg;
        fpu_q    <= n_fpu;
      end
      if (wr4) cr4_q <= n4;
    end
  end

  hflags_t hf;
  always_comb begin
    hf.pe     = pe_q;
    hf.addseg = addseg_q;
    hf.mp     = fpu_q[0];
    hf.em     = fpu_q[1];
    hf.ts     = fpu_q[2];
    hf.lma    = lma_q;
    hf.cs64   = cs64_q;
    hf.osfxsr = cr4_q[X_OSFXSR];
  end

  assign cr0_o      = cr0_q;
  assign cr4_o      = cr4_q;
  assign efer_lma_o = lma_q;
  assign hflags_o   = hf;
  assign flush_o    = flush_q;
  assign ip_trunc_o = trunc_q;

  AST_ET_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr0 |=> cr0_o[P_ET]); // R3
  AST_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr0 && !wr4) |=> ($stable(cr0_o) && $stable(cr4_o))); // R2
  AST_QUIET_CR0: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0 && !wr4 && wr_data[P_PG] == cr0_o[P_PG] && wr_data[P_WP] == cr0_o[P_WP]
     && wr_data[P_PE] == cr0_o[P_PE]) |=> !flush_o); // R4
  AST_ADDSEG_REAL: assert property (@(posedge clk) disable iff (!rst_n)
    !hflags_o[0] |-> hflags_o[1]); // R5
  AST_NO_LM_NO_PAE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0 && !cr4_o[X_PAE] && !efer_lma_i) |=> !efer_lma_o); // R6
  AST_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ip_trunc_o |-> (!efer_lma_o && !hflags_o[6] && !cr0_o[P_PG])); // R7
  AST_TRUNC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ip_trunc_o |=> !ip_trunc_o); // R7
  AST_FX_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr4 && !sse_i) |=> !cr4_o[X_OSFXSR]); // R10
  AST_FX_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    hflags_o[7] == cr4_o[X_OSFXSR]); // R10
endmodule

// File: tb/sim_crw_top.sv
module sim_crw_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_idx;
  logic [31:0] wr_data;
  logic        efer_lme_i, efer_lma_i, sse_i, cs_long_i;
  logic [31:0] cr0_o, cr4_o;
  logic        efer_lma_o, flush_o, ip_trunc_o;
  logic [7:0]  hflags_o;

  always #4 clk = ~clk;

  crw_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .efer_lme_i(efer_lme_i), .efer_lma_i(efer_lma_i), .sse_i(sse_i), .cs_long_i(cs_long_i),
    .cr0_o(cr0_o), .cr4_o(cr4_o), .efer_lma_o(efer_lma_o), .hflags_o(hflags_o),
    .flush_o(flush_o), .ip_trunc_o(ip_trunc_o)
  );

  typedef struct packed {
    logic [2:0]  idx;
    logic [31:0] data;
    logic        lme;
    logic        lma_in;
    logic        sse;
    logic [31:0] e0;
    logic [31:0] e4;
    logic        elma;
    logic [7:0]  ehf;
    logic        efl;
    logic        etr;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{3'd0, 32'h0000000B, 1'b0, 1'b0, 1'b1, 32'h0000001B, 32'h0, 1'b0, 8'h17, 1'b1, 1'b0}, // R5 R3
    '{3'd0, 32'h00000005, 1'b0, 1'b0, 1'b1, 32'h00000015, 32'h0, 1'b0, 8'h0B, 1'b0, 1'b0}, // R4 quiet
    '{3'd0, 32'h00010001, 1'b0, 1'b0, 1'b1, 32'h00010011, 32'h0, 1'b0, 8'h03, 1'b1, 1'b0}, // R4 WP
    '{3'd3, 32'hFFFFFFFF, 1'b0, 1'b0, 1'b1, 32'h00010011, 32'h0, 1'b0, 8'h03, 1'b0, 1'b0}, // R2
    '{3'd0, 32'h80000001, 1'b1, 1'b0, 1'b1, 32'h80000011, 32'h0, 1'b0, 8'h03, 1'b1, 1'b0}, // R6 no PAE
    '{3'd4, 32'h000002B0, 1'b0, 1'b0, 1'b0, 32'h80000011, 32'h000000B0, 1'b0, 8'h03, 1'b1, 1'b0}, // R10
    '{3'd4, 32'h000002B0, 1'b0, 1'b0, 1'b1, 32'h80000011, 32'h000002B0, 1'b0, 8'h83, 1'b0, 1'b0}, // R9
    '{3'd0, 32'h00000001, 1'b0, 1'b0, 1'b1, 32'h00000011, 32'h000002B0, 1'b0, 8'h83, 1'b1, 1'b0}, // R7 no LMA
    '{3'd0, 32'h80000001, 1'b1, 1'b0, 1'b1, 32'h80000011, 32'h000002B0, 1'b1, 8'hE3, 1'b1, 1'b0}, // R6 entry
    '{3'd0, 32'h80010001, 1'b1, 1'b1, 1'b1, 32'h80010011, 32'h000002B0, 1'b1, 8'hE3, 1'b1, 1'b0}, // R8
    '{3'd0, 32'h00000001, 1'b1, 1'b1, 1'b1, 32'h00000011, 32'h000002B0, 1'b0, 8'h83, 1'b1, 1'b1}, // R7 exit
    '{3'd0, 32'h80000001, 1'b0, 1'b0, 1'b1, 32'h80000011, 32'h000002B0, 1'b0, 8'h83, 1'b1, 1'b0}, // R6 no LME
    '{3'd0, 32'h80000000, 1'b0, 1'b0, 1'b1, 32'h80000010, 32'h000002B0, 1'b0, 8'h82, 1'b1, 1'b0}, // R5 PE off
    '{3'd4, 32'h00000000, 1'b0, 1'b0, 1'b1, 32'h80000010, 32'h00000000, 1'b0, 8'h02, 1'b1, 1'b0}  // R9
  };

  string rq [NV];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [31:0] e0, input logic [31:0] e4,
                         input logic elma, input logic [7:0] ehf, input logic efl, input logic etr);
    chk(req, "cr0", cr0_o, e0);
    chk(req, "cr4", cr4_o, e4);
    chk(req, "lma", {31'd0, efer_lma_o}, {31'd0, elma});
    chk(req, "hflags", {24'd0, hflags_o}, {24'd0, ehf});
    chk(req, "flush", {31'd0, flush_o}, {31'd0, efl});
    chk(req, "trunc", {31'd0, ip_trunc_o}, {31'd0, etr});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rq = '{"R5", "R4", "R4", "R2", "R6", "R10", "R9", "R7", "R6", "R8", "R7", "R6", "R5", "R9"};
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    efer_lme_i = 1'b0; efer_lma_i = 1'b0; sse_i = 1'b1; cs_long_i = 1'b1;
    repeat (3) @(negedge clk);
    chk_all("R1", 32'h60000010, 32'h0, 1'b0, 8'h02, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1", 32'h60000010, 32'h0, 1'b0, 8'h02, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      wr_en = 1'b1; wr_idx = TBL[i].idx; wr_data = TBL[i].data;
      efer_lme_i = TBL[i].lme; efer_lma_i = TBL[i].lma_in; sse_i = TBL[i].sse;
      @(negedge clk);
      chk_all(rq[i], TBL[i].e0, TBL[i].e4, TBL[i].elma, TBL[i].ehf, TBL[i].efl, TBL[i].etr);
      wr_en = 1'b0; efer_lma_i = TBL[i].elma;
      @(negedge clk);
      // pulses last one cycle (R4, R7)
      chk("R4", "flush idle", {31'd0, flush_o}, 32'd0);
      chk("R7", "trunc idle", {31'd0, ip_trunc_o}, 32'd0);
    end

    // R2: strobe low with index 0 is ignored
    wr_en = 1'b0; wr_idx = 3'd0; wr_data = 32'hFFFFFFFF;
    @(negedge clk);
    chk("R2", "cr0 no strobe", cr0_o, 32'h80000010);
    chk("R2", "cr4 no strobe", cr4_o, 32'h0);

    // R9: non-paging extension bit change raises no flush
    wr_en = 1'b1; wr_idx = 3'd4; wr_data = 32'h00000008;
    @(negedge clk);
    chk("R9", "cr4 other bit", cr4_o, 32'h00000008);
    chk("R9", "flush other bit", {31'd0, flush_o}, 32'd0);
    wr_data = 32'h00000018;
    @(negedge clk);
    chk("R9", "flush on PSE", {31'd0, flush_o}, 32'd1);
    wr_en = 1'b0;
    @(negedge clk);

    // R1: reset in the middle of activity
    rst_n = 1'b0;
    @(negedge clk);
    chk_all("R1", 32'h60000010, 32'h0, 1'b0, 8'h02, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule